// File: doc/BRIEF.md
# Two-Output Cascaded Interrupt Controller

This block gathers 224 interrupt request lines and presents them to a parent controller as two interrupt outputs. Every source has its own configuration. It can trigger on an edge or on a level, be active high or active low, be enabled or blocked, and be steered to either output. Edge events are held in a latch until software writes a one to the matching clear bit. Level sources are never latched: they count as pending only while the input is active.

Sources are grouped in words of 32, so source n sits at bit n mod 32 of word n/32 in every per-source array. Software reaches the controller through two 32-bit register regions, a configuration bank and a status bank. The status bank gives, for each output, the masked pending word of every group. It also gives one summary word that flags which groups hold pending work for each output. A handler reads the summary first, then the single group word it needs.

Each request input is synchronised with two flops. It is then normalised by the polarity bit, and then goes through edge detection. Each output is a registered OR of all masked pending sources routed to it.

Top module: `dual_out_intc`

## Requirements
- R1: After a synchronous active-low reset, both interrupt outputs are low and every configuration word reads back as zero.
- R2: The configuration bank (region select 0) holds four arrays of seven words. Type is at word addresses 0..6, polarity at 7..13, priority at 14..20 and mask at 21..27. Source n is bit n mod 32 of the word at array base + n/32, and each word reads back what was last written to it.
- R3: With its type bit at 0 (level), a source is pending exactly while its normalised input is active. The normalised input is the input itself when the polarity bit is 0 and its inverse when the polarity bit is 1. A level source is never latched.
- R4: With its type bit at 1 (edge), a rising edge of the normalised input sets a latch. The latch keeps the source pending after the input returns to idle.
- R5: Writing a word to status address 0..6 (clear words) clears the edge latch of every source whose bit is 1 in that word. Bits written as 0 leave their latch unchanged.
- R6: A source whose mask bit is 0 appears in no masked pending word, in no summary bit and on no output.
- R7: A pending, enabled source with its priority bit at 1 goes to output 0 and shows in the output-0 words at status addresses 14..20. With its priority bit at 0 it goes to output 1 and shows in the output-1 words at status addresses 7..13.
- R8: The summary word at status address 31 has bit g set when output-1 group word g is non-zero and bit 8+g set when output-0 group word g is non-zero. All other bits are zero.
- R9: Each output is a register that goes high the cycle after any masked pending source is routed to it. It goes low the cycle after the last such source goes away.
- R10: Read data is valid in the cycle after a read strobe. Clear words, config addresses 28..31 and status addresses 21..30 read as zero, and writes to them other than the clear words change nothing.
- R11: A request input reaches the pending logic through two synchronising flops. A level source's output therefore changes at the third rising clock edge after its input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 224 | Raw interrupt request lines, one per source |
| reg_sel | input | 1 | Region select: 0 configuration bank, 1 status bank |
| reg_addr | input | 5 | Word address within the selected region |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_out0 | output | 1 | Interrupt output 0 to the parent controller |
| irq_out1 | output | 1 | Interrupt output 1 to the parent controller |

## Verification
The checker watches four behaviours on every cycle. It requires blocked sources to be absent from the routed pending vectors and never routed to both outputs at once. It requires each output to follow its routed pending set one cycle later, in both directions, and the summary's reserved bits to stay zero. It also requires unused configuration addresses to read zero. Edge latching, write-one-to-clear with zero bits left alone, the three-edge synchroniser latency and the level-versus-edge distinction all depend on stimulus history. Only the bench's scenarios show them, by comparing the status words, summary and outputs against a model of latches and normalised inputs.

// File: rtl/intc_pkg.sv
// Package: shared constants and array identifiers for the cascaded
// interrupt controller. Assumes 32-bit register words.
package intc_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned SUMMARY_IDX = 31;   // status word holding the group summary
    localparam int unsigned OUT0_SHIFT  = 8;    // summary field offset for output 0
    localparam int unsigned NUM_ARR     = 4;    // configuration arrays

    // Configuration arrays in bank order; the order sets the address layout.
    typedef enum logic [1:0] {
        ARR_TYPE = 2'd0,
        ARR_POL  = 2'd1,
        ARR_PRIO = 2'd2,
        ARR_MASK = 2'd3
    } cfg_arr_e;
endpackage

// File: rtl/intc_src_group.sv
// Module: one group of interrupt sources. Synchronises raw requests with two
// flops, applies polarity, detects rising edges of the normalised signal and
// keeps edge latches. Assumes the clear vector is a single-cycle pulse.
module intc_src_group #(
    parameter int unsigned GW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] irq_raw,
    input  logic [GW-1:0] cfg_edge,
    input  logic [GW-1:0] cfg_low,
    input  logic [GW-1:0] clr_pulse,
    output logic [GW-1:0] pend
);
    logic [GW-1:0] sync_a, sync_b, norm_prev, edge_hold;
    logic [GW-1:0] norm;

    assign norm = sync_b ^ cfg_low;

    // Two-flop synchroniser for the raw request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
        end else begin
            sync_a <= irq_raw;
            sync_b <= sync_a;
        end
    end

    // Edge latch: a new edge wins over a clear in the same cycle; level mode holds it empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            norm_prev <= '0;
            edge_hold <= '0;
        end else begin
            norm_prev <= norm;
            edge_hold <= cfg_edge & ((norm & ~norm_prev) | (edge_hold & ~clr_pulse));
        end
    end

    // Pending selection: latched event in edge mode, live level otherwise.
    always_comb begin
        pend = (cfg_edge & edge_hold) | (~cfg_edge & norm);
    end
endmodule

// File: rtl/intc_regs.sv
// Module: register decode for both regions. Stores the four configuration
// arrays, produces clear pulses and the group summary, and registers read
// data. Assumes NUM_GRP <= 8 and 4*NUM_GRP <= SUMMARY_IDX.
module intc_regs
    import intc_pkg::*;
#(
    parameter int unsigned NUM_GRP = 7,
    parameter int unsigned ADDR_W  = 5,
    localparam int unsigned PAD_W  = NUM_GRP * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [PAD_W-1:0]  mp0_all,
    input  logic [PAD_W-1:0]  mp1_all,
    output logic [PAD_W-1:0]  type_all,
    output logic [PAD_W-1:0]  pol_all,
    output logic [PAD_W-1:0]  prio_all,
    output logic [PAD_W-1:0]  mask_all,
    output logic [PAD_W-1:0]  clr_all,
    output logic [WORD_W-1:0] summary
);
    localparam int unsigned ST_OUT1_BASE = NUM_GRP;
    localparam int unsigned ST_OUT0_BASE = 2 * NUM_GRP;

    logic [NUM_ARR-1:0][NUM_GRP-1:0][WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] rd_next;

    assign type_all = cfg_q[ARR_TYPE];
    assign pol_all  = cfg_q[ARR_POL];
    assign prio_all = cfg_q[ARR_PRIO];
    assign mask_all = cfg_q[ARR_MASK];

    // Configuration word storage, written when the address hits an array word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (reg_we && !reg_sel) begin
            for (int a = 0; a < int'(NUM_ARR); a++) begin
                for (int g = 0; g < int'(NUM_GRP); g++) begin
                    if (reg_addr == ADDR_W'(a * NUM_GRP + g)) cfg_q[a][g] <= reg_wdata;
                end
            end
        end
    end

    // Clear pulses and summary bits, one slice per group.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign clr_all[g*WORD_W +: WORD_W] =
            (reg_we && reg_sel && reg_addr == ADDR_W'(g)) ? reg_wdata : '0;
    end

    // Summary word: per-group non-zero flags for each output in separate fields.
    always_comb begin
        summary = '0;
        for (int g = 0; g < int'(NUM_GRP); g++) begin
            summary[g]              = |mp1_all[g*WORD_W +: WORD_W];
            summary[OUT0_SHIFT + g] = |mp0_all[g*WORD_W +: WORD_W];
        end
    end

    // Read multiplexer: unmatched addresses give zero.
    always_comb begin
        rd_next = '0;
        if (!reg_sel) begin
            for (int a = 0; a < int'(NUM_ARR); a++) begin
                for (int g = 0; g < int'(NUM_GRP); g++) begin
                    if (reg_addr == ADDR_W'(a * NUM_GRP + g)) rd_next = cfg_q[a][g];
                end
            end
        end else begin
            for (int g = 0; g < int'(NUM_GRP); g++) begin
                if (reg_addr == ADDR_W'(ST_OUT1_BASE + g)) rd_next = mp1_all[g*WORD_W +: WORD_W];
                if (reg_addr == ADDR_W'(ST_OUT0_BASE + g)) rd_next = mp0_all[g*WORD_W +: WORD_W];
            end
            if (reg_addr == ADDR_W'(SUMMARY_IDX)) rd_next = summary;
        end
    end

    // Read data register, loaded on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_re) reg_rdata <= rd_next;
    end
endmodule

// File: rtl/intc_outreg.sv
// Module: registered OR reduction of the routed pending vectors into the
// two interrupt outputs. Assumes inputs are already masked and routed.
module intc_outreg #(
    parameter int unsigned VW = 224
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] mp0_all,
    input  logic [VW-1:0] mp1_all,
    output logic          irq_out0,
    output logic          irq_out1
);
    // Output flops: one cycle from the routed pending set to the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out0 <= 1'b0;
            irq_out1 <= 1'b0;
        end else begin
            irq_out0 <= |mp0_all;
            irq_out1 <= |mp1_all;
        end
    end
endmodule

// File: rtl/dual_out_intc.sv
// Module: top of the two-output cascaded interrupt controller. Pads the
// sources to whole groups, instantiates one source group per word, masks and
// routes the pending bits, and drives the output flops. Assumes NUM_SRC
// fits in 8 groups so the summary fields do not overlap.
module dual_out_intc
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 224,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_sel,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic               reg_re,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_out0,
    output logic               irq_out1
);
    localparam int unsigned NUM_GRP = (NUM_SRC + WORD_W - 1) / WORD_W;
    localparam int unsigned PAD_W   = NUM_GRP * WORD_W;
    localparam logic [PAD_W-1:0] VALID = {PAD_W{1'b1}} >> (PAD_W - NUM_SRC);

    logic [PAD_W-1:0] irq_pad, type_all, pol_all, prio_all, mask_all, clr_all;
    logic [PAD_W-1:0] pend_all, mp0_all, mp1_all;
    logic [WORD_W-1:0] summary;

    assign irq_pad = PAD_W'(irq_in);

    // Source groups, one per 32-bit word.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_src
        intc_src_group #(.GW(WORD_W)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_raw  (irq_pad[g*WORD_W +: WORD_W]),
            .cfg_edge (type_all[g*WORD_W +: WORD_W]),
            .cfg_low  (pol_all[g*WORD_W +: WORD_W]),
            .clr_pulse(clr_all[g*WORD_W +: WORD_W]),
            .pend     (pend_all[g*WORD_W +: WORD_W])
        );
    end

    // Masking and routing: priority 1 goes to output 0, priority 0 to output 1.
    always_comb begin
        mp0_all = pend_all & mask_all & VALID & prio_all;
        mp1_all = pend_all & mask_all & VALID & ~prio_all;
    end

    intc_regs #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_sel  (reg_sel),
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mp0_all  (mp0_all),
        .mp1_all  (mp1_all),
        .type_all (type_all),
        .pol_all  (pol_all),
        .prio_all (prio_all),
        .mask_all (mask_all),
        .clr_all  (clr_all),
        .summary  (summary)
    );

    intc_outreg #(.VW(PAD_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .mp0_all (mp0_all),
        .mp1_all (mp1_all),
        .irq_out0(irq_out0),
        .irq_out1(irq_out1)
    );
endmodule

// File: rtl/intc_chk.sv
// Module: assertion checker for the cascaded interrupt controller, bound to
// the top module. Observes routed pending vectors, mask, summary and the
// register port.
module intc_chk #(
    parameter int unsigned PAD_W   = 224,
    parameter int unsigned NUM_GRP = 7,
    parameter int unsigned ADDR_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_out0,
    input logic              irq_out1,
    input logic              reg_re,
    input logic              reg_sel,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic [PAD_W-1:0]  mp0_all,
    input logic [PAD_W-1:0]  mp1_all,
    input logic [PAD_W-1:0]  mask_all,
    input logic [31:0]       summary
);
    localparam logic [31:0] SUM_OK = ((32'd1 << NUM_GRP) - 32'd1) * 32'h0000_0101;

    AST_RESET_QUIET:  assert property (@(posedge clk) !rst_n |=> (!irq_out0 && !irq_out1)); // R1
    AST_OUT0_RISE:    assert property (@(posedge clk) disable iff (!rst_n) (|mp0_all) |=> irq_out0); // R9
    AST_OUT0_FALL:    assert property (@(posedge clk) disable iff (!rst_n) !(|mp0_all) |=> !irq_out0); // R9
    AST_OUT1_RISE:    assert property (@(posedge clk) disable iff (!rst_n) (|mp1_all) |=> irq_out1); // R9
    AST_OUT1_FALL:    assert property (@(posedge clk) disable iff (!rst_n) !(|mp1_all) |=> !irq_out1); // R9
    AST_MASK_BLOCKS:  assert property (@(posedge clk) disable iff (!rst_n) ((mp0_all | mp1_all) & ~mask_all) == '0); // R6
    AST_ROUTE_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) (mp0_all & mp1_all) == '0); // R7
    AST_SUM_RSVD:     assert property (@(posedge clk) disable iff (!rst_n) (summary & ~SUM_OK) == 32'd0); // R8
    AST_UNUSED_READ:  assert property (@(posedge clk) disable iff (!rst_n)
                          (reg_re && !reg_sel && reg_addr >= ADDR_W'(4 * NUM_GRP)) |=> reg_rdata == 32'd0); // R10
endmodule

bind dual_out_intc intc_chk #(.PAD_W(PAD_W), .NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_out0 (irq_out0),
    .irq_out1 (irq_out1),
    .reg_re   (reg_re),
    .reg_sel  (reg_sel),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .mp0_all  (mp0_all),
    .mp1_all  (mp1_all),
    .mask_all (mask_all),
    .summary  (summary)
);

// File: tb/dual_out_intc_bench.sv
module dual_out_intc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 224;
    localparam int NG = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_in = '0;
    logic          reg_sel = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic          reg_we = 1'b0;
    logic          reg_re = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_out0, irq_out1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of configuration, latches and last normalised input.
    logic [NS-1:0] m_type = '0, m_pol = '0, m_prio = '0, m_mask = '0;
    logic [NS-1:0] m_latch = '0, m_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_out_intc u_dual_out_intc (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out0(irq_out0), .irq_out1(irq_out1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int addr, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_addr = 5'(addr); reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic sel, input int addr, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_addr = 5'(addr); reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Write a config word and mirror it in the model.
    task automatic cfg_wr(input int arr, input int g, input logic [31:0] d);
        wr(1'b0, arr * NG + g, d);
        case (arr)
            0: m_type[g*32 +: 32] = d;
            1: m_pol[g*32 +: 32]  = d;
            2: m_prio[g*32 +: 32] = d;
            default: m_mask[g*32 +: 32] = d;
        endcase
    endtask

    function automatic logic [NS-1:0] exp_pend();
        return (m_type & m_latch) | (~m_type & (irq_in ^ m_pol));
    endfunction

    function automatic logic [31:0] exp_summary(input logic [NS-1:0] e0, input logic [NS-1:0] e1);
        logic [31:0] s = '0;
        for (int g = 0; g < NG; g++) begin
            s[g]     = |e1[g*32 +: 32];
            s[8 + g] = |e0[g*32 +: 32];
        end
        return s;
    endfunction

    // Compare outputs, routed status words and summary with the model.
    task automatic check_all(input string tag);
        logic [NS-1:0] mp, e0, e1;
        logic [31:0] d;
        mp = exp_pend() & m_mask;
        e0 = mp & m_prio;
        e1 = mp & ~m_prio;
        chk({"R9 out0 ", tag}, 32'(irq_out0), 32'(|e0));
        chk({"R9 out1 ", tag}, 32'(irq_out1), 32'(|e1));
        for (int g = 0; g < NG; g++) begin
            rd(1'b1, NG + g, d);
            chk({"R7 out1 word ", tag}, d, e1[g*32 +: 32]);
            rd(1'b1, 2 * NG + g, d);
            chk({"R6 out0 word ", tag}, d, e0[g*32 +: 32]);
        end
        rd(1'b1, 31, d);
        chk({"R8 summary ", tag}, d, exp_summary(e0, e1));
    endtask

    function automatic logic [NS-1:0] rand_vec(input int sparse);
        logic [NS-1:0] v;
        for (int g = 0; g < NG; g++) begin
            logic [31:0] w = $urandom();
            if (sparse != 0) w = w & $urandom() & $urandom();
            if (($urandom() % 5) == 0) w = '0;
            v[g*32 +: 32] = w;
        end
        return v;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        wait_n(3);
        rst_n = 1'b1;

        // R1: reset state.
        chk("R1 out0", 32'(irq_out0), 0);
        chk("R1 out1", 32'(irq_out1), 0);
        rd(1'b0, 0, d);  chk("R1 type word", d, 0);
        rd(1'b0, 21, d); chk("R1 mask word", d, 0);

        // R11 / R9: level source 0 routed to output 0, latency and release.
        cfg_wr(3, 0, 32'h1);
        cfg_wr(2, 0, 32'h1);
        wait_n(4);
        irq_in[0] = 1'b1;
        wait_n(2); chk("R11 out0 after 2 edges", 32'(irq_out0), 0);
        wait_n(1); chk("R11 out0 after 3 edges", 32'(irq_out0), 1);
        irq_in[0] = 1'b0;
        wait_n(2); chk("R9 out0 held", 32'(irq_out0), 1);
        wait_n(1); chk("R9 out0 released", 32'(irq_out0), 0);

        // R3: active-low level, not latched.
        cfg_wr(1, 0, 32'h1);
        wait_n(4); chk("R3 low level pending", 32'(irq_out0), 1);
        irq_in[0] = 1'b1;
        wait_n(4); chk("R3 level not latched", 32'(irq_out0), 0);
        irq_in[0] = 1'b0;
        wait_n(4);
        cfg_wr(1, 0, 32'h0);

        // R4 / R5: edge latch, zero bits ignored, one bits clear.
        cfg_wr(0, 0, 32'h1);
        wr(1'b1, 0, 32'hFFFF_FFFF);
        wait_n(3); chk("R5 after clear", 32'(irq_out0), 0);
        irq_in[0] = 1'b1; wait_n(4);
        irq_in[0] = 1'b0; wait_n(4);
        chk("R4 edge latched", 32'(irq_out0), 1);
        wr(1'b1, 0, 32'hFFFF_FFFE);
        wait_n(2); chk("R5 zero bit ignored", 32'(irq_out0), 1);
        wr(1'b1, 0, 32'h1);
        wait_n(1); chk("R5 one bit clears", 32'(irq_out0), 0);
        rd(1'b1, 2 * NG, d); chk("R5 word after clear", d, 0);

        // R10: unused addresses and clear words read zero; writes ignored.
        wr(1'b0, 29, 32'hDEAD_BEEF);
        rd(1'b0, 29, d); chk("R10 cfg 29", d, 0);
        rd(1'b0, 31, d); chk("R10 cfg 31", d, 0);
        rd(1'b1, 25, d); chk("R10 status 25", d, 0);
        rd(1'b1, 0, d);  chk("R10 clear word read", d, 0);
        rd(1'b0, 21, d); chk("R10 mask intact", d, 32'h1);

        // Random epochs: new configuration, then random inputs and clears.
        for (int ep = 0; ep < 6; ep++) begin
            logic [NS-1:0] vt, vp, vr, vm;
            vt = rand_vec(0); vp = rand_vec(0); vr = rand_vec(0); vm = rand_vec(0);
            for (int g = 0; g < NG; g++) begin
                cfg_wr(0, g, vt[g*32 +: 32]);
                cfg_wr(1, g, vp[g*32 +: 32]);
                cfg_wr(2, g, vr[g*32 +: 32]);
                cfg_wr(3, g, vm[g*32 +: 32]);
            end
            for (int a = 0; a < 4; a++) begin
                for (int g = 0; g < NG; g++) begin
                    logic [NS-1:0] src;
                    src = (a == 0) ? m_type : (a == 1) ? m_pol : (a == 2) ? m_prio : m_mask;
                    rd(1'b0, a * NG + g, d);
                    chk("R2 config readback", d, src[g*32 +: 32]);
                end
            end
            wait_n(6);
            for (int g = 0; g < NG; g++) wr(1'b1, g, 32'hFFFF_FFFF);
            m_latch = '0;
            m_prev = irq_in ^ m_pol;
            wait_n(3);
            check_all("R3 epoch start");
            for (int st = 0; st < 8; st++) begin
                logic [NS-1:0] nn;
                int cg;
                logic [31:0] cw;
                irq_in = rand_vec(st % 2);
                nn = irq_in ^ m_pol;
                m_latch = m_latch | (m_type & nn & ~m_prev);
                m_prev = nn;
                wait_n(6);
                check_all("R4 step");
                cg = int'($urandom() % NG);
                cw = $urandom();
                wr(1'b1, cg, cw);
                m_latch[cg*32 +: 32] = m_latch[cg*32 +: 32] & ~cw;
                wait_n(2);
                check_all("R5 random clear");
            end
        end

        finish_run();
    end
endmodule